// File: doc/BRIEF.md
# Reset Sequencer with Vector Fetch

This block collects every reset source of a small 8-bit processor and starts the core at its reset vector. The sources are a power-good input, a bidirectional active-low reset pin, and single-cycle requests from a watchdog and from a clock monitor. While any reset is in progress, the block holds the core in reset and keeps the vector high-byte address on the address bus.

On power-up the block stretches reset for a fixed number of cycles and pulls the pin low for that whole time. After an internal request it also pulls the pin low for a short, fixed time. It reads the pin through a two-flop synchronizer and measures how long the pin stays low while the block itself is not pulling it. This count is what separates an external reset from an internal one.

Once the pin reads high again, the block fetches the two vector bytes over a memory interface. The memory returns data one cycle after the address. The block then loads the program counter, presents the new PC as a dummy opcode fetch, and frees the core with a one-cycle start pulse. A sticky cause register records why the last resets happened, and the core clears its bits by writing ones.

Top module: `reset_vector_sequencer`

## Requirements
- R1: While `pwr_good` is low, `pin_pull` and `core_rst` are high and `cause` reads 4'b0001. After `pwr_good` rises, `pin_pull` stays high for exactly POR_CYCLES (default 4064) clock cycles.
- R2: Once the core is running or fetching, a low level on the synchronized pin starts a reset. `core_rst` then stays high until the synchronized pin reads high again.
- R3: `cause[1]` (external) is set when the pin is released after at least EXT_MIN (default 8) consecutive low samples taken while the block was not pulling it. A shorter pulse resets the core but leaves `cause` unchanged.
- R4: A watchdog request sets `cause[2]`, and a clock-monitor request sets `cause[3]`. Either request makes the block pull the pin low for exactly DRIVE_CYCLES (default 4) cycles. If both arrive together, only the watchdog is recorded.
- R5: While reset is held (power-on stretch, internal pull, or waiting for the pin), `mem_addr` is 0x3FFE.
- R6: After the pin reads high, `mem_addr` shows 0x3FFE for one cycle and then 0x3FFF for two cycles. In the second of those two cycles, `pc_load` pulses with `pc_value` = {byte at 0x3FFE, byte at 0x3FFF}.
- R7: In the cycle after `pc_load`, `start` pulses for one cycle, `mem_addr` shows the new PC (the dummy opcode fetch) and `core_rst` goes low.
- R8: A watchdog, clock-monitor or pin request that arrives during the vector fetch restarts the sequence from the hold state, and the vector is read again.
- R9: `cause` bits stay set until a write with `cause_clr_we` high clears the bits that are one in `cause_clr`. A bit set in the same cycle wins over the clear.
- R10: The pin passes through two flops, so a pin falling edge reaches `core_rst` on the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Low while supply is not valid; asynchronous power-on reset |
| reset_pin_n | input | 1 | Level read back from the reset pin |
| pin_pull | output | 1 | Open-drain pull-down enable for the reset pin |
| wdog_req | input | 1 | Watchdog reset request |
| clkmon_req | input | 1 | Clock-monitor reset request |
| core_rst | output | 1 | Reset to the core |
| cause | output | 4 | Sticky cause: [0] power-on, [1] external, [2] watchdog, [3] clock monitor |
| cause_clr_we | input | 1 | Write strobe for clearing cause bits |
| cause_clr | input | 4 | Write-one-to-clear mask for cause |
| mem_addr | output | 16 | Address bus |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 16 | Program counter value to load |
| start | output | 1 | One-cycle core release pulse |

## Verification
The assertions assume three things about the inputs. The watchdog, clock-monitor and clear inputs are synchronous to `clk`. The read data follows the address with exactly one cycle of latency. `pwr_good` stays low long enough to span a clock edge. The stimulus changes every input only on falling clock edges and serves reads from a registered model memory. It also gives the requests as single-cycle pulses, so that each pulse starts exactly one internal reset. Pin pulses are made in whole cycles, from three cycles upward, so that the lengths around the external threshold are covered on both sides.

// File: rtl/reset_vector_sequencer.sv
module reset_vector_sequencer #(
  parameter int DATA_W       = 8,
  parameter int POR_CYCLES   = 4064,
  parameter int EXT_MIN      = 8,
  parameter int DRIVE_CYCLES = 4,
  parameter logic [2*DATA_W-1:0] VEC_ADDR = 16'h3FFE
) (
  input  logic                clk,
  input  logic                pwr_good,
  input  logic                reset_pin_n,
  output logic                pin_pull,
  input  logic                wdog_req,
  input  logic                clkmon_req,
  output logic                core_rst,
  output logic [3:0]          cause,
  input  logic                cause_clr_we,
  input  logic [3:0]          cause_clr,
  output logic [2*DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_value,
  output logic                start
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int CNT_W  = $clog2(POR_CYCLES + 1);
  localparam int LOW_W  = $clog2(EXT_MIN + 1);

  typedef enum logic [2:0] {S_POR, S_IDRV, S_HOLD, S_FHI, S_FLO, S_LOAD, S_STRT, S_RUN} st_t;

  st_t               state, nxt;
  logic [1:0]        sync;
  logic [CNT_W-1:0]  cnt;
  logic [LOW_W-1:0]  low_cnt;
  logic [DATA_W-1:0] pch;
  logic [ADDR_W-1:0] pc_r;

  wire pin_s   = sync[1];
  wire live    = (state >= S_FHI);
  wire wd_hit  = live & wdog_req;
  wire cm_hit  = live & ~wdog_req & clkmon_req;
  wire pin_hit = live & ~pin_s;
  wire ext_hit = (state == S_HOLD) & pin_s & (low_cnt >= LOW_W'(EXT_MIN));

  assign pin_pull = (state == S_POR) || (state == S_IDRV);
  assign core_rst = !((state == S_STRT) || (state == S_RUN));
  assign pc_load  = (state == S_LOAD);
  assign start    = (state == S_STRT);
  assign pc_value = pc_load ? {pch, mem_rdata} : pc_r;

  always_comb begin
    case (state)
      S_FLO, S_LOAD: mem_addr = VEC_ADDR + 1'b1;
      S_STRT, S_RUN: mem_addr = pc_r;
      default:       mem_addr = VEC_ADDR;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_POR:   if (cnt == CNT_W'(POR_CYCLES - 1)) nxt = S_HOLD;
      S_IDRV:  if (cnt == CNT_W'(DRIVE_CYCLES - 1)) nxt = S_HOLD;
      S_HOLD:  if (pin_s) nxt = S_FHI;
      S_FHI:   nxt = S_FLO;
      S_FLO:   nxt = S_LOAD;
      S_LOAD:  nxt = S_STRT;
      S_STRT:  nxt = S_RUN;
      default: nxt = state;
    endcase
    if (wd_hit || cm_hit) nxt = S_IDRV;
    else if (pin_hit)     nxt = S_HOLD;
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      state   <= S_POR;
      sync    <= '0;
      cnt     <= '0;
      low_cnt <= '0;
      pch     <= '0;
      pc_r    <= '0;
      cause   <= 4'b0001;
    end else begin
      state <= nxt;
      sync  <= {sync[0], reset_pin_n};
      cnt   <= (nxt != state || !pin_pull) ? '0 : cnt + CNT_W'(1);
      if (pin_pull || pin_s)                 low_cnt <= '0;
      else if (low_cnt != LOW_W'(EXT_MIN))   low_cnt <= low_cnt + LOW_W'(1);
      if (state == S_FLO)  pch  <= mem_rdata;
      if (state == S_LOAD) pc_r <= {pch, mem_rdata};
      cause <= (cause & ~(cause_clr_we ? cause_clr : 4'b0000)) | {cm_hit, wd_hit, ext_hit, 1'b0};
    end
  end

  a_r5_hold_vector: assert property (@(posedge clk) disable iff (!pwr_good)
    pin_pull |-> (mem_addr == VEC_ADDR) && core_rst);
  a_r6_fetch_order: assert property (@(posedge clk) disable iff (!pwr_good)
    pc_load |-> ($past(mem_addr) == VEC_ADDR + 1'b1) && ($past(mem_addr, 2) == VEC_ADDR));
  a_r7_start_after_load: assert property (@(posedge clk) disable iff (!pwr_good)
    start |-> $past(pc_load) && !core_rst);
  a_r7_start_single: assert property (@(posedge clk) disable iff (!pwr_good)
    start |=> !start);
  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!pwr_good)
    !cause_clr_we |=> ((cause & $past(cause)) == $past(cause)));
  a_r4_wdog_pulls: assert property (@(posedge clk) disable iff (!pwr_good)
    (wdog_req && !core_rst) |=> pin_pull && cause[2]);
  a_r2_low_pin_holds: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == S_HOLD && !pin_s) |=> core_rst);
endmodule

// File: tb/test_reset_vector_sequencer.sv
module test_reset_vector_sequencer;
  localparam int POR = 4064;
  localparam int EXTN = 8;
  localparam int DRV = 4;

  logic clk = 0, pwr_good = 0, ext_n = 1, wdog_req = 0, clkmon_req = 0;
  logic cause_clr_we = 0;
  logic [3:0] cause_clr = 0;
  logic [7:0] mem_rdata = 0;
  logic [7:0] vh = 8'h12, vl = 8'h34;
  wire reset_pin_n;
  logic pin_pull, core_rst, pc_load, start;
  logic [3:0] cause;
  logic [15:0] mem_addr, pc_value;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign reset_pin_n = ext_n & ~pin_pull;

  reset_vector_sequencer #(.POR_CYCLES(POR), .EXT_MIN(EXTN), .DRIVE_CYCLES(DRV)) i_reset_vector_sequencer (
    .clk(clk), .pwr_good(pwr_good), .reset_pin_n(reset_pin_n), .pin_pull(pin_pull),
    .wdog_req(wdog_req), .clkmon_req(clkmon_req), .core_rst(core_rst), .cause(cause),
    .cause_clr_we(cause_clr_we), .cause_clr(cause_clr), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_value(pc_value), .start(start));

  always @(posedge clk)
    mem_rdata <= (mem_addr == 16'h3FFE) ? vh : (mem_addr == 16'h3FFF) ? vl : (mem_addr[7:0] ^ 8'h5A);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 por,1 internal pull,2 hold,3 fetch hi,4 fetch lo,5 load,6 start,7 run
  int mph, mcnt, mlow, nph;
  logic ms1, ms2, ps, pin, pull, live;
  logic [3:0] mcause, setv;
  logic [15:0] mpc;

  always @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      mph = 0; mcnt = 0; mlow = 0; ms1 = 0; ms2 = 0; mcause = 4'b0001; mpc = 0;
    end else begin
      pull = (mph <= 1);
      pin = ext_n & ~pull;
      ps = ms2; ms2 = ms1; ms1 = pin;
      live = (mph >= 3);
      setv = 0;
      if (live && wdog_req) setv[2] = 1;
      else if (live && clkmon_req) setv[3] = 1;
      if (mph == 2 && ps && mlow >= EXTN) setv[1] = 1;
      nph = mph;
      case (mph)
        0: if (mcnt == POR - 1) nph = 2;
        1: if (mcnt == DRV - 1) nph = 2;
        2: if (ps) nph = 3;
        3, 4, 5, 6: nph = mph + 1;
        default: ;
      endcase
      if (setv[2] || setv[3]) nph = 1;
      else if (live && !ps) nph = 2;
      if (mph == 5) mpc = {vh, vl};
      mcnt = (nph != mph || !pull) ? 0 : mcnt + 1;
      mlow = (pull || ps) ? 0 : ((mlow < EXTN) ? mlow + 1 : mlow);
      mcause = (mcause & ~(cause_clr_we ? cause_clr : 4'b0000)) | setv;
      mph = nph;
    end
  end

  always @(negedge clk) if (!done) begin
    logic [15:0] ea;
    ea = (mph == 4 || mph == 5) ? 16'h3FFF : (mph >= 6) ? mpc : 16'h3FFE;
    chk(pin_pull == (mph <= 1), "R1/R4 pin_pull vs model", pin_pull, mph <= 1);
    chk(core_rst == !(mph >= 6), "R2 core_rst vs model", core_rst, !(mph >= 6));
    chk(mem_addr == ea, "R5/R6 mem_addr vs model", mem_addr, ea);
    chk(pc_load == (mph == 5), "R6 pc_load vs model", pc_load, mph == 5);
    if (mph == 5) chk(pc_value == {vh, vl}, "R6 pc_value vs model", pc_value, {vh, vl});
    chk(start == (mph == 6), "R7 start vs model", start, mph == 6);
    chk(cause == mcause, "R3/R4/R9 cause vs model", cause, mcause);
  end

  logic [15:0] got_pc;
  task automatic wait_start(input string tag);
    int n = 0;
    got_pc = 16'hxxxx;
    while (!start && n < 300) begin
      @(negedge clk);
      if (pc_load) got_pc = pc_value;
      n++;
    end
    chk(start == 1, tag, start, 1);
  endtask

  task automatic clear_cause(input logic [3:0] m);
    @(negedge clk); cause_clr_we = 1; cause_clr = m;
    @(negedge clk); cause_clr_we = 0; cause_clr = 0;
  endtask

  task automatic ext_pulse(input int len);
    @(negedge clk); ext_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk(core_rst == 0, "R10 two-flop latency", core_rst, 0);
    @(negedge clk);
    chk(core_rst == 1, "R2 pin low accepted", core_rst, 1);
    repeat (len - 3) @(negedge clk);
    ext_n = 1;
    wait_start("R2 restart after pin pulse");
  endtask

  task automatic pulse_req(input bit wd, input bit cm);
    int n = 0;
    @(negedge clk); wdog_req = wd; clkmon_req = cm;
    @(negedge clk); wdog_req = 0; clkmon_req = 0;
    while (pin_pull && n < 100) begin n++; @(negedge clk); end
    chk(n == DRV, "R4 internal pull length", n, DRV);
    wait_start("R4 restart after internal request");
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    chk(pin_pull == 1 && core_rst == 1, "R1 reset state", {pin_pull, core_rst}, 2'b11);
    chk(cause == 4'b0001, "R1 power-on cause", cause, 1);
    pwr_good = 1;
    while (pin_pull && n < 10000) begin n++; @(negedge clk); end
    chk(n == POR, "R1 power-on stretch length", n, POR);
    wait_start("R6 first start");
    chk(got_pc == 16'h1234, "R6 loaded vector", got_pc, 16'h1234);
    chk(mem_addr == 16'h1234 && core_rst == 0, "R7 dummy fetch at new PC", mem_addr, 16'h1234);
    clear_cause(4'b0001);
    chk(cause == 4'b0000, "R9 write-one clear", cause, 0);

    ext_pulse(5);
    chk(cause == 4'b0000, "R3 short pulse not external", cause, 0);
    ext_pulse(EXTN - 1);
    chk(cause == 4'b0000, "R3 pulse one below threshold", cause, 0);
    ext_pulse(EXTN);
    chk(cause == 4'b0010, "R3 pulse at threshold", cause, 2);
    clear_cause(4'b0010);
    ext_pulse(30);
    chk(cause == 4'b0010, "R2 long pin hold external", cause, 2);
    clear_cause(4'b1111);

    pulse_req(1, 0);
    chk(cause == 4'b0100, "R4 watchdog cause", cause, 4);
    @(negedge clk); cause_clr_we = 1; cause_clr = 4'b1111; wdog_req = 1;
    @(negedge clk); cause_clr_we = 0; cause_clr = 0; wdog_req = 0;
    chk(cause == 4'b0100, "R9 set wins over clear", cause, 4);
    wait_start("R9 restart");
    clear_cause(4'b0100);
    pulse_req(1, 1);
    chk(cause == 4'b0100, "R4 watchdog priority", cause, 4);
    clear_cause(4'b0100);
    pulse_req(0, 1);
    chk(cause == 4'b1000, "R4 clock-monitor cause", cause, 8);
    clear_cause(4'b1000);

    vh = 8'hAB; vl = 8'hCD;
    @(negedge clk); wdog_req = 1;
    @(negedge clk); wdog_req = 0;
    n = 0;
    while (!(mem_addr == 16'h3FFF && core_rst) && n < 100) begin n++; @(negedge clk); end
    chk(pc_load == 0, "R8 restart before load", pc_load, 0);
    clkmon_req = 1;
    @(negedge clk); clkmon_req = 0;
    chk(pin_pull == 1 && pc_load == 0, "R8 fetch restarted", pin_pull, 1);
    wait_start("R8 restart completes");
    chk(got_pc == 16'hABCD, "R8 vector read again", got_pc, 16'hABCD);
    chk(cause == 4'b1100, "R8 both causes kept", cause, 12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(60000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule